// File: doc/BRIEF.md
# Serial Front End for a 16-bit Voltage DAC

This block sits on the digital side of a 16-bit voltage-output DAC and accepts writes over a three-wire serial link. The link has an active-low frame select, a serial clock and a data line. The three link pins are brought into the system clock domain through synchronizer flops, and the serial clock edges are detected there. While the select is low, each falling serial clock edge shifts one data bit into the frame, most significant bit first.

A frame is 24 bits. The low 16 bits carry the DAC code and the next two bits carry the output mode. The six bits at the top of the frame are don't-care. When the 24th falling edge arrives, the code and mode registers load together and a one-cycle update strobe is raised. If the select rises before the 24th edge, the frame is dropped. Edges after the 24th in the same frame are ignored. At reset the code register holds either zero scale or midscale, chosen by a build parameter, and it keeps that value until the first complete frame.

Top module: `serdac_rx`

## Requirements
- R1: While reset is asserted and after it is released, `dac_code_o` is 0 when `RESET_MID`=0 or 16'h8000 when `RESET_MID`=1, `pd_mode_o` is 2'b00 and `update_o` is low, until the first complete frame.
- R2: Bits are taken on falling edges of `sclk_i` while `sel_n_i` is low, first bit = frame bit 23. After the 24th falling edge, `dac_code_o` equals frame bits 15..0.
- R3: On the same commit, `pd_mode_o` equals frame bits 17..16. The encoding is 00 normal, 01, 10 and 11 the three power-down loads.
- R4: Frame bits 23..18 have no effect on any output.
- R5: If `sel_n_i` rises after fewer than 24 falling edges, `dac_code_o` and `pd_mode_o` keep their previous values and no update strobe is raised.
- R6: Falling edges after the 24th in the same frame are ignored. The committed value is built from the first 24 bits, and there is only one strobe per frame.
- R7: Edges of `sclk_i` while `sel_n_i` is high shift nothing and change no output. The next frame starts from an empty count.
- R8: `update_o` is high for exactly one clock per committed frame.
- R9: `dac_code_o` and `pd_mode_o` change only in the cycle in which `update_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n_i | input | 1 | Active-low frame select from the serial host |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdata_i | input | 1 | Serial data, most significant bit first |
| dac_code_o | output | 16 | Committed DAC code |
| pd_mode_o | output | 2 | Committed output mode, 00 normal |
| update_o | output | 1 | One-cycle strobe on each committed frame |

## Verification
A miscounted bit counter shows up at the ports in one of two ways. A frame may commit early, with the code shifted by one or more bits. Or a frame may commit after the select rises, which gives an extra strobe. Either is visible within a few clocks of the frame's end. A shift register that gains or loses a bit corrupts the next committed code and mode. Stale data left over from an aborted frame would show up in the following full frame. So the bench follows each abort and each run of stray clock edges with a complete write, and then compares the code, the mode and the running strobe count against its own model.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  // Mode field encoding
  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_PD_A   = 2'b01,
    MODE_PD_B   = 2'b10,
    MODE_PD_C   = 2'b11
  } out_mode_e;

  // Index of each line in the synchronized link bus
  localparam int unsigned LNK_DIN  = 0;
  localparam int unsigned LNK_SCLK = 1;
  localparam int unsigned LNK_SEL  = 2;
  localparam int unsigned LNK_W    = 3;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= IDLE;
          else        stg_q[s] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= IDLE;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned PAY_W   = 18,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_s_i,
  input  logic             sclk_s_i,
  input  logic             din_s_i,
  output logic [PAY_W-1:0] payload_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             sclk_prev_q;
  logic             fall;
  logic [PAY_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             sh_en;

  assign fall  = sclk_prev_q & ~sclk_s_i;
  assign sh_en = ~sel_s_i & fall & (cnt_q < CNT_W'(FRAME_W));

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (sel_s_i) begin
      cnt_d = '0;
    end else if (sh_en) begin
      sh_d  = {sh_q[PAY_W-2:0], din_s_i};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(FRAME_W - 1)) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b1;
      cnt_q       <= '0;
      done_q      <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s_i;
      cnt_q       <= cnt_d;
      done_q      <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign payload_o = sh_q;
  assign done_o    = done_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/serdac_regs.sv
module serdac_regs #(
  parameter int unsigned CODE_W    = 16,
  parameter int unsigned MODE_W    = 2,
  parameter bit          RESET_MID = 1'b0,
  localparam int unsigned PAY_W    = CODE_W + MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [PAY_W-1:0]  payload_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              upd_o
);
  localparam logic [CODE_W-1:0] RST_CODE =
    RESET_MID ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  logic [CODE_W-1:0] code_q, code_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              upd_q;

  always_comb begin
    code_d = code_q;
    mode_d = mode_q;
    if (load_i) begin
      code_d = payload_i[CODE_W-1:0];
      mode_d = payload_i[PAY_W-1:CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RST_CODE;
      mode_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      mode_q <= mode_d;
      upd_q  <= load_i;
    end
  end

  assign code_o = code_q;
  assign mode_o = mode_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/serdac_rx.sv
module serdac_rx #(
  parameter int unsigned CODE_W    = 16,
  parameter int unsigned MODE_W    = 2,
  parameter int unsigned FRAME_W   = 24,
  parameter int unsigned SYNC_STG  = 2,
  parameter bit          RESET_MID = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [MODE_W-1:0] pd_mode_o,
  output logic              update_o
);
  import serdac_pkg::*;

  localparam int unsigned PAY_W = CODE_W + MODE_W;
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam logic [LNK_W-1:0] LNK_IDLE = 3'b110;

  // Reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  logic [LNK_W-1:0] lnk_raw, lnk_s;
  assign lnk_raw = {sel_n_i, sclk_i, sdata_i};

  serdac_sync #(.W(LNK_W), .STAGES(SYNC_STG), .IDLE(LNK_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   (lnk_raw),
    .q_o   (lnk_s)
  );

  logic [PAY_W-1:0] payload;
  logic             frame_done;
  logic [CNT_W-1:0] bit_cnt;

  serdac_shifter #(.FRAME_W(FRAME_W), .PAY_W(PAY_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .sel_s_i   (lnk_s[LNK_SEL]),
    .sclk_s_i  (lnk_s[LNK_SCLK]),
    .din_s_i   (lnk_s[LNK_DIN]),
    .payload_o (payload),
    .done_o    (frame_done),
    .cnt_o     (bit_cnt)
  );

  serdac_regs #(.CODE_W(CODE_W), .MODE_W(MODE_W), .RESET_MID(RESET_MID)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .load_i    (frame_done),
    .payload_i (payload),
    .code_o    (dac_code_o),
    .mode_o    (pd_mode_o),
    .upd_o     (update_o)
  );
endmodule

// File: rtl/serdac_rx_chk.sv
module serdac_rx_chk #(
  parameter int unsigned CODE_W  = 16,
  parameter int unsigned MODE_W  = 2,
  parameter int unsigned FRAME_W = 24,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              sel_s,
  input logic              frame_done,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CODE_W-1:0] dac_code_o,
  input logic [MODE_W-1:0] pd_mode_o,
  input logic              update_o
);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_q_n)
    update_o |=> !update_o);

  a_r8_strobe_follows_done: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_done |=> update_o);

  a_r5_no_strobe_without_done: assert property (@(posedge clk) disable iff (!rst_q_n)
    !frame_done |=> !update_o);

  a_r9_hold_between_writes: assert property (@(posedge clk) disable iff (!rst_q_n)
    !update_o |-> ($stable(dac_code_o) && $stable(pd_mode_o)));

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_q_n)
    bit_cnt <= CNT_W'(FRAME_W));

  a_r7_idle_clears_count: assert property (@(posedge clk) disable iff (!rst_q_n)
    sel_s |=> (bit_cnt == '0));

  a_r2_done_at_full_count: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_done |-> (bit_cnt == CNT_W'(FRAME_W)));
endmodule

bind serdac_rx serdac_rx_chk #(.CODE_W(CODE_W), .MODE_W(MODE_W), .FRAME_W(FRAME_W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .sel_s      (lnk_s[serdac_pkg::LNK_SEL]),
  .frame_done (frame_done),
  .bit_cnt    (bit_cnt),
  .dac_code_o (dac_code_o),
  .pd_mode_o  (pd_mode_o),
  .update_o   (update_o)
);

// File: tb/tb_serdac_rx.sv
module tb_serdac_rx;
  localparam bit RESET_MID = 1'b1;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b1, sdata = 1'b0;
  logic [15:0] dac_code;
  logic [1:0]  pd_mode;
  logic        update;

  int checks = 0, fails = 0, upd_seen = 0, exp_upd = 0;
  logic [15:0] exp_code;
  logic [1:0]  exp_mode;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serdac_rx #(.RESET_MID(RESET_MID)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdata_i(sdata),
    .dac_code_o(dac_code), .pd_mode_o(pd_mode), .update_o(update)
  );

  always @(negedge clk) if (rst_n && update) upd_seen++;

  function automatic logic [15:0] reset_code(bit mid);
    return mid ? 16'h8000 : 16'h0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " code"}, 32'(dac_code), 32'(exp_code));
    chk({req, " mode"}, 32'(pd_mode), 32'(exp_mode));
    chk({req, " strobes"}, 32'(upd_seen), 32'(exp_upd));
  endtask

  // Drive one frame: nfall falling edges, first 24 from w, MSB first
  task automatic frame(logic [23:0] w, int nfall);
    sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nfall; i++) begin
      sdata = (i < 24) ? w[23-i] : 1'($urandom);
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    sel_n = 1'b1;
    repeat (12) @(negedge clk);
    if (nfall >= 24) begin
      exp_code = w[15:0];
      exp_mode = w[17:16];
      exp_upd++;
    end
  endtask

  // Toggle the serial clock with the select held high
  task automatic stray(int n);
    for (int i = 0; i < n; i++) begin
      sdata = 1'($urandom);
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    exp_code = reset_code(RESET_MID);
    exp_mode = 2'b00;
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk("R1 code in reset", 32'(dac_code), 32'(exp_code));
    chk("R1 strobe in reset", 32'(update), 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_all("R1 after release");

    // R2/R3: plain write, power-down mode 01
    frame(24'h01_A5C3, 24);
    check_all("R2 R3 first write");
    // R3: remaining mode codes
    frame(24'h02_1234, 24); check_all("R3 mode 10");
    frame(24'h03_FFFF, 24); check_all("R3 mode 11");
    frame(24'h00_0001, 24); check_all("R3 mode 00");
    // R4: only top bits differ from a previous word
    frame(24'hFC_0001, 24); check_all("R4 top bits ignored");
    // R5: aborted after 23 edges and after 1 edge
    frame(24'h02_DEAD, 23); check_all("R5 abort at 23");
    frame(24'h03_BEEF, 1);  check_all("R5 abort at 1");
    frame(24'h01_0F0F, 0);  check_all("R5 empty select pulse");
    // R6: surplus edges after the 24th
    frame(24'h02_7777, 31); check_all("R6 surplus edges");
    // R7: edges with select high, then a full frame
    stray(9);               check_all("R7 stray edges");
    frame(24'h01_8001, 24); check_all("R7 frame after stray");
    // R8/R9: back-to-back frames, strobe count and held values
    frame(24'h00_4321, 24); frame(24'h03_0000, 24);
    check_all("R8 R9 back to back");

    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [23:0] w = 24'($urandom);
      int n = ($urandom % 4 == 0) ? int'($urandom % 24) : 24 + int'($urandom % 5);
      if ($urandom % 5 == 0) stray(1 + int'($urandom % 5));
      frame(w, n);
      check_all(n >= 24 ? "R2 R3 R6 random" : "R5 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule